// File: doc/BRIEF.md
# Nonlinear-Filter Keystream Generator

This block produces a keystream from a 48-bit shift register. Each output bit comes from a two-level table filter applied to the register, not from a register bit directly. A start pulse captures a 48-bit key, a 32-bit serial number and a 32-bit initialisation value (IV). The register is loaded from the low key bits and the serial number. The block then mixes the register for 32 cycles, feeding back the filter output combined with one IV bit and one upper key bit per cycle. After that it waits for step requests.

A step request in single-bit mode advances the register by one linear-feedback step and returns one keystream bit. A request in byte mode runs eight such steps and returns them packed into a byte, earliest bit first in the most significant position. The block signals busy while it mixes and ready while it can accept a request. Each result comes with a one-cycle valid pulse.

The controller has four named states. IDLE holds after reset until the first start. MIX runs the 32 initialisation cycles. READY waits for requests. BYTE runs the eight packed steps. The transitions are:
- IDLE→MIX on start.
- MIX→READY after the 32nd mixing cycle.
- READY→MIX on start.
- READY→BYTE on a byte-mode request.
- READY→READY on a single-bit request.
- BYTE→READY after the eighth step.
- BYTE→MIX on start.

Top module: `nlfc_keystream`

## Requirements
- R1: While reset is low and after its release, ready_o, busy_o, bit_valid_o and byte_valid_o are 0. ks_bit_o and ks_byte_o are 0.
- R2: A start accepted on a clock edge loads the register with key_i[15:0] in bits 47..32 and serial_i in bits 31..0. It also captures key_i[47:16] and iv_i for the mixing phase.
- R3: After an accepted start, busy_o is 1 for exactly 32 cycles and then ready_o is 1. Mixing cycle i (i = 0..31) shifts the register right by one. It sets bit 47 to the filter of the shifted register XOR iv_i bit i XOR key_i bit i+16.
- R4: A start during the mixing phase is ignored. The busy span is not lengthened, and the keystream follows the first key, serial and IV.
- R5: A keystream step computes feedback as the XOR of register bits 0, 2, 3, 6, 7, 8, 16, 22, 23, 26, 30, 41, 42, 43, 46 and 47. It shifts the register right by one and places the feedback in bit 47.
- R6: The keystream bit is the filter of the register after the shift. The filter works in two levels:
  - Five 4-bit indices come from bit groups {1,2,4,5}, {7,11,13,14}, {16,20,22,25}, {27,28,30,32} and {33,42,43,45}, with the first listed bit as the LSB.
  - Groups one and five select from 16'h2C79. Groups two to four select from 16'h6671.
  - The five results form an index, with group one as the LSB, into 32'h7907287B.
- R7: In READY with byte_mode_i low, each cycle with step_i high performs one step. bit_valid_o is 1 and ks_bit_o holds that bit in the following cycle. Requests may come back to back every cycle.
- R8: In READY with byte_mode_i high, a step_i pulse drops ready_o in the next cycle. The block then runs eight steps. byte_valid_o is 1 with ready_o, and ks_byte_o holds the eight bits, the first in bit 7, in the ninth cycle after the request.
- R9: When start_i and step_i are high in the same cycle outside the mixing phase, start wins. No step is taken, no valid pulse follows, and busy_o is 1 in the next cycle.
- R10: step_i is ignored in IDLE and during mixing. No valid pulse follows, and the later keystream is unchanged.
- R11: A start during the byte phase aborts it. No byte_valid_o follows, and mixing restarts with the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load-and-mix request |
| key_i | input | 48 | Secret key |
| serial_i | input | 32 | Serial number loaded into the low register half |
| iv_i | input | 32 | Initialisation value mixed during startup |
| step_i | input | 1 | Keystream request |
| byte_mode_i | input | 1 | 1 selects an eight-step byte, 0 a single bit |
| ready_o | output | 1 | Block can accept a keystream request |
| busy_o | output | 1 | Mixing phase in progress |
| ks_bit_o | output | 1 | Last single keystream bit |
| bit_valid_o | output | 1 | One-cycle pulse: ks_bit_o is new |
| ks_byte_o | output | 8 | Last packed keystream byte, earliest bit in bit 7 |
| byte_valid_o | output | 1 | One-cycle pulse: ks_byte_o is new |

## Verification
Start and a keystream request can arrive in the same cycle. Start must win, so that a re-key never leaks a step from the old state. The bench provokes this twice:
- It raises start_i together with step_i while READY. It then requires busy_o, no valid pulse in the next cycle, and a keystream that matches a fresh model run on the new inputs.
- It raises start_i in the middle of a byte run. It requires that no byte_valid_o appears and that the new vector's keystream follows.

The reverse overlap, a start during mixing, is judged by the busy length and by the keystream still following the first vector.

// File: rtl/nlfc_pkg.sv
package nlfc_pkg;

    localparam int unsigned STATE_W    = 48;
    localparam int unsigned SERIAL_W   = 32;
    localparam int unsigned KEY_W      = 48;
    localparam int unsigned INIT_STEPS = 32;
    localparam int unsigned IV_W       = INIT_STEPS;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned KEY_LO_W   = STATE_W - SERIAL_W;
    localparam int unsigned CNT_W      = $clog2(INIT_STEPS);

    localparam int unsigned NUM_GRP    = 5;
    localparam int unsigned GRP_SZ     = 4;

    // feedback tap set of the linear register
    localparam logic [STATE_W-1:0] FB_MASK = 48'hCE00_44C1_01CD;

    // filter tables
    localparam logic [15:0] TBL_OUTER = 16'h2C79;
    localparam logic [15:0] TBL_INNER = 16'h6671;
    localparam logic [31:0] TBL_FINAL = 32'h7907287B;

    // bit taps of each filter group, element 0 is the index LSB
    localparam int unsigned GRP_BITS [NUM_GRP][GRP_SZ] = '{
        '{ 1,  2,  4,  5},
        '{ 7, 11, 13, 14},
        '{16, 20, 22, 25},
        '{27, 28, 30, 32},
        '{33, 42, 43, 45}
    };

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MIX   = 2'd1,
        PH_READY = 2'd2,
        PH_BYTE  = 2'd3
    } phase_e;

endpackage

// File: rtl/nlfc_filter.sv
module nlfc_filter
    import nlfc_pkg::*;
(
    input  logic [STATE_W-1:0] st_i,
    output logic               bit_o
);

    logic [NUM_GRP-1:0] sel;
    logic               unused_taps;

    assign unused_taps = ^st_i;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [GRP_SZ-1:0] idx;

        for (genvar b = 0; b < GRP_SZ; b++) begin : g_tap
            assign idx[b] = st_i[GRP_BITS[g][b]];
        end

        if (g == 0 || g == NUM_GRP - 1) begin : g_outer
            assign sel[g] = TBL_OUTER[idx];
        end else begin : g_inner
            assign sel[g] = TBL_INNER[idx];
        end
    end

    assign bit_o = TBL_FINAL[sel];

endmodule

// File: rtl/nlfc_state.sv
module nlfc_state
    import nlfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic               mix_mode_i,
    input  logic               mix_bit_i,
    input  logic               filt_i,
    input  logic [STATE_W-1:0] load_val_i,
    output logic [STATE_W-1:0] shifted_o
);

    logic [STATE_W-1:0] state_q;
    logic               lin_fb;
    logic               top_bit;

    assign lin_fb    = ^(state_q & FB_MASK);
    assign top_bit   = mix_mode_i ? (filt_i ^ mix_bit_i) : lin_fb;
    assign shifted_o = {1'b0, state_q[STATE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= load_val_i;
        end else if (shift_i) begin
            state_q <= {top_bit, state_q[STATE_W-1:1]};
        end
    end

    AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_q == $past(load_val_i)); // R2

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> state_q[STATE_W-2:0] == $past(state_q[STATE_W-1:1])); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(state_q)); // R10

endmodule

// File: rtl/nlfc_ctrl.sv
module nlfc_ctrl
    import nlfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic byte_mode_i,
    output logic load_o,
    output logic shift_o,
    output logic mix_mode_o,
    output logic byte_step_o,
    output logic emit_bit_o,
    output logic emit_byte_o,
    output logic ready_o,
    output logic busy_o
);

    localparam logic [CNT_W-1:0] MIX_LAST  = CNT_W'(INIT_STEPS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

    phase_e           phase_q;
    phase_e           phase_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decision
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) phase_d = PH_MIX;
            end
            PH_MIX: begin
                if (cnt_q == MIX_LAST) phase_d = PH_READY;
            end
            PH_READY: begin
                if (start_i)                    phase_d = PH_MIX;
                else if (step_i && byte_mode_i) phase_d = PH_BYTE;
            end
            PH_BYTE: begin
                if (start_i)                 phase_d = PH_MIX;
                else if (cnt_q == BYTE_LAST) phase_d = PH_READY;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // step counter shared by the mixing and byte phases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_o || (phase_q == PH_READY && phase_d == PH_BYTE)) begin
            cnt_q <= '0;
        end else if (phase_q == PH_MIX || phase_q == PH_BYTE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        load_o      = 1'b0;
        shift_o     = 1'b0;
        mix_mode_o  = 1'b0;
        byte_step_o = 1'b0;
        emit_bit_o  = 1'b0;
        emit_byte_o = 1'b0;
        ready_o     = 1'b0;
        busy_o      = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                load_o = start_i;
            end
            PH_MIX: begin
                busy_o     = 1'b1;
                mix_mode_o = 1'b1;
                shift_o    = 1'b1;
            end
            PH_READY: begin
                ready_o    = 1'b1;
                load_o     = start_i;
                emit_bit_o = !start_i && step_i && !byte_mode_i;
                shift_o    = emit_bit_o;
            end
            PH_BYTE: begin
                load_o      = start_i;
                byte_step_o = !start_i;
                shift_o     = !start_i;
                emit_byte_o = !start_i && (cnt_q == BYTE_LAST);
            end
            default: begin
                load_o = 1'b0;
            end
        endcase
    end

    AST_MIX_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MIX && start_i && cnt_q != MIX_LAST)
            |=> (phase_q == PH_MIX && cnt_q == $past(cnt_q) + 1'b1)); // R4

    AST_MIX_END: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MIX && cnt_q == MIX_LAST) |=> (ready_o && !busy_o)); // R3

    AST_MIX_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> cnt_q == '0); // R3

endmodule

// File: rtl/nlfc_keystream.sv
module nlfc_keystream
    import nlfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [KEY_W-1:0]    key_i,
    input  logic [SERIAL_W-1:0] serial_i,
    input  logic [IV_W-1:0]     iv_i,
    input  logic                step_i,
    input  logic                byte_mode_i,
    output logic                ready_o,
    output logic                busy_o,
    output logic                ks_bit_o,
    output logic                bit_valid_o,
    output logic [BYTE_W-1:0]   ks_byte_o,
    output logic                byte_valid_o
);

    logic                  load;
    logic                  shift;
    logic                  mix_mode;
    logic                  byte_step;
    logic                  emit_bit;
    logic                  emit_byte;
    logic                  filt_bit;
    logic [STATE_W-1:0]    shifted;
    logic [INIT_STEPS-1:0] key_mix_q;
    logic [IV_W-1:0]       iv_mix_q;
    logic [BYTE_W-1:0]     byte_acc_q;
    logic                  mix_bit;

    nlfc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .byte_mode_i (byte_mode_i),
        .load_o      (load),
        .shift_o     (shift),
        .mix_mode_o  (mix_mode),
        .byte_step_o (byte_step),
        .emit_bit_o  (emit_bit),
        .emit_byte_o (emit_byte),
        .ready_o     (ready_o),
        .busy_o      (busy_o)
    );

    nlfc_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_i    (shift),
        .mix_mode_i (mix_mode),
        .mix_bit_i  (mix_bit),
        .filt_i     (filt_bit),
        .load_val_i ({key_i[KEY_LO_W-1:0], serial_i}),
        .shifted_o  (shifted)
    );

    nlfc_filter u_filter (
        .st_i  (shifted),
        .bit_o (filt_bit)
    );

    assign mix_bit = key_mix_q[0] ^ iv_mix_q[0];

    // mixing operands, consumed LSB first, one bit per mixing cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_mix_q <= '0;
            iv_mix_q  <= '0;
        end else if (load) begin
            key_mix_q <= key_i[KEY_LO_W +: INIT_STEPS];
            iv_mix_q  <= iv_i;
        end else if (shift && mix_mode) begin
            key_mix_q <= {1'b0, key_mix_q[INIT_STEPS-1:1]};
            iv_mix_q  <= {1'b0, iv_mix_q[IV_W-1:1]};
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_bit_o     <= 1'b0;
            bit_valid_o  <= 1'b0;
            byte_acc_q   <= '0;
            ks_byte_o    <= '0;
            byte_valid_o <= 1'b0;
        end else begin
            bit_valid_o  <= emit_bit;
            byte_valid_o <= emit_byte;
            if (emit_bit) ks_bit_o <= filt_bit;
            if (byte_step) byte_acc_q <= {byte_acc_q[BYTE_W-2:0], filt_bit};
            if (emit_byte) ks_byte_o <= {byte_acc_q[BYTE_W-2:0], filt_bit};
        end
    end

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !bit_valid_o && !byte_valid_o)); // R9

    AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid_o && byte_valid_o)); // R8

    AST_BYTE_RETURNS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> ready_o); // R8

    AST_BIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> $past(ready_o)); // R7

    AST_NO_RESULT_IN_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!bit_valid_o && !byte_valid_o)); // R10

endmodule

// File: tb/tb_nlfc_keystream.sv
module tb_nlfc_keystream;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] key_i = '0;
    logic [31:0] serial_i = '0;
    logic [31:0] iv_i = '0;
    logic        step_i = 1'b0;
    logic        byte_mode_i = 1'b0;
    logic        ready_o;
    logic        busy_o;
    logic        ks_bit_o;
    logic        bit_valid_o;
    logic [7:0]  ks_byte_o;
    logic        byte_valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [47:0] ms;

    // stimulus table: key, serial, iv, single steps, bytes
    localparam logic [127:0] VEC [6] = '{
        {48'h524B494D4E4F, 32'h69574349, 32'h72456E65, 8'd6, 8'd2},
        {48'h000000000000, 32'h00000000, 32'h00000000, 8'd4, 8'd2},
        {48'hFFFFFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd4, 8'd2},
        {48'h0123456789AB, 32'hCAFEF00D, 32'h13579BDF, 8'd9, 8'd3},
        {48'h800000000001, 32'h80000001, 32'h00000001, 8'd3, 8'd1},
        {48'h5A5AA5A53C3C, 32'hDEADBEEF, 32'h0BADF00D, 8'd5, 8'd2}
    };

    nlfc_keystream dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .key_i        (key_i),
        .serial_i     (serial_i),
        .iv_i         (iv_i),
        .step_i       (step_i),
        .byte_mode_i  (byte_mode_i),
        .ready_o      (ready_o),
        .busy_o       (busy_o),
        .ks_bit_o     (ks_bit_o),
        .bit_valid_o  (bit_valid_o),
        .ks_byte_o    (ks_byte_o),
        .byte_valid_o (byte_valid_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    function automatic logic m_filter(input logic [47:0] s);
        logic [15:0] ta;
        logic [15:0] tb;
        logic [31:0] tc;
        logic [4:0]  i5;
        ta = 16'h2C79;
        tb = 16'h6671;
        tc = 32'h7907287B;
        i5[0] = ta[{s[5],  s[4],  s[2],  s[1]}];
        i5[1] = tb[{s[14], s[13], s[11], s[7]}];
        i5[2] = tb[{s[25], s[22], s[20], s[16]}];
        i5[3] = tb[{s[32], s[30], s[28], s[27]}];
        i5[4] = ta[{s[45], s[43], s[42], s[33]}];
        return tc[i5];
    endfunction

    function automatic logic [47:0] m_init(input logic [47:0] k, input logic [31:0] sn,
                                           input logic [31:0] iv);
        logic [47:0] x;
        x = {k[15:0], sn};
        for (int i = 0; i < 32; i++) begin
            x = x >> 1;
            x[47] = m_filter(x) ^ iv[i] ^ k[i + 16];
        end
        return x;
    endfunction

    task automatic m_step(output logic b);
        logic fb;
        fb = ms[0] ^ ms[2] ^ ms[3] ^ ms[6] ^ ms[7] ^ ms[8] ^ ms[16] ^ ms[22]
           ^ ms[23] ^ ms[26] ^ ms[30] ^ ms[41] ^ ms[42] ^ ms[43] ^ ms[46] ^ ms[47];
        ms = {fb, ms[47:1]};
        b  = m_filter(ms);
    endtask

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the load edge
    task automatic pulse_start(input logic [47:0] k, input logic [31:0] sn,
                               input logic [31:0] iv);
        start_i  = 1'b1;
        key_i    = k;
        serial_i = sn;
        iv_i     = iv;
        @(negedge clk);
        start_i  = 1'b0;
        ms = m_init(k, sn, iv);
    endtask

    // counts busy cycles, starting at the negedge right after the load edge
    task automatic wait_mix(input string req);
        int n;
        n = 0;
        while (busy_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 32, req, n, 32);
        chk(ready_o === 1'b1, req, ready_o, 1);
    endtask

    task automatic one_bit(input string req);
        logic e;
        step_i      = 1'b1;
        byte_mode_i = 1'b0;
        @(negedge clk);
        step_i = 1'b0;
        m_step(e);
        chk(bit_valid_o === 1'b1, req, bit_valid_o, 1);
        chk(ks_bit_o === e, req, ks_bit_o, e);
    endtask

    task automatic one_byte(input string req);
        logic [7:0] e;
        logic       b;
        step_i      = 1'b1;
        byte_mode_i = 1'b1;
        @(negedge clk);
        step_i      = 1'b0;
        byte_mode_i = 1'b0;
        chk(ready_o === 1'b0, req, ready_o, 0);
        repeat (8) @(negedge clk);
        e = '0;
        for (int i = 0; i < 8; i++) begin
            m_step(b);
            e = {e[6:0], b};
        end
        chk(byte_valid_o === 1'b1, req, byte_valid_o, 1);
        chk(ks_byte_o === e, req, ks_byte_o, e);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic e;
        int   n;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({ready_o, busy_o, bit_valid_o, byte_valid_o, ks_bit_o, ks_byte_o} === '0,
            "R1 during reset", {ready_o, busy_o, bit_valid_o, byte_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ready_o, busy_o, bit_valid_o, byte_valid_o, ks_bit_o, ks_byte_o} === '0,
            "R1 after reset", {ready_o, busy_o, bit_valid_o, byte_valid_o}, 0);

        // R10: request in IDLE has no effect
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        chk(bit_valid_o === 1'b0 && ready_o === 1'b0, "R10 idle step",
            {ready_o, bit_valid_o}, 0);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            pulse_start(VEC[v][127:80], VEC[v][79:48], VEC[v][47:16]);
            wait_mix("R3 busy span / ready");
            for (int s = 0; s < int'(VEC[v][15:8]); s++) one_bit("R2 R5 R6 R7 bit");
            for (int s = 0; s < int'(VEC[v][7:0]); s++) one_byte("R8 byte");
        end

        // random vectors
        for (int v = 0; v < 4; v++) begin
            pulse_start({$urandom(), $urandom()}, $urandom(), $urandom());
            wait_mix("R3 random");
            one_byte("R8 random");
            one_bit("R7 random");
        end

        // R7: back-to-back single steps
        step_i      = 1'b1;
        byte_mode_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            m_step(e);
            chk(bit_valid_o === 1'b1 && ks_bit_o === e, "R7 back-to-back",
                {bit_valid_o, ks_bit_o}, {1'b1, e});
        end
        step_i = 1'b0;

        // R4 / R10: start and step during mixing are ignored
        pulse_start(48'h1122334455AA, 32'h0F1E2D3C, 32'h89ABCDEF);
        n = 0;
        while (busy_o === 1'b1 && n < 100) begin
            n++;
            start_i = (n == 6);
            step_i  = (n == 12);
            if (n == 6) begin
                key_i    = 48'hDEADDEADDEAD;
                serial_i = 32'h55555555;
                iv_i     = 32'hAAAAAAAA;
            end
            @(negedge clk);
            start_i = 1'b0;
            step_i  = 1'b0;
            if (n == 12) chk(bit_valid_o === 1'b0, "R10 step during mix", bit_valid_o, 0);
        end
        chk(n == 32, "R4 busy not extended", n, 32);
        one_byte("R4 keystream of first vector");
        one_bit("R4 keystream of first vector");

        // R9: start and step in the same cycle, start wins
        start_i     = 1'b1;
        step_i      = 1'b1;
        byte_mode_i = 1'b0;
        key_i       = 48'h0F0F0F0F0F0F;
        serial_i    = 32'h12345678;
        iv_i        = 32'h9ABCDEF0;
        @(negedge clk);
        start_i = 1'b0;
        step_i  = 1'b0;
        chk(bit_valid_o === 1'b0 && busy_o === 1'b1, "R9 start beats step",
            {busy_o, bit_valid_o}, 2'b10);
        ms = m_init(48'h0F0F0F0F0F0F, 32'h12345678, 32'h9ABCDEF0);
        wait_mix("R9 remix");
        one_byte("R9 fresh keystream");

        // R11: start aborts a byte run
        step_i      = 1'b1;
        byte_mode_i = 1'b1;
        @(negedge clk);
        step_i      = 1'b0;
        byte_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        pulse_start(48'hA5A5F0F01234, 32'h00FF00FF, 32'hFEDCBA98);
        n = 0;
        while (busy_o === 1'b1 && n < 100) begin
            if (byte_valid_o !== 1'b0) n = 200;
            n++;
            @(negedge clk);
        end
        chk(n == 32, "R11 abort and remix, no byte result", n, 32);
        one_byte("R11 new keystream");
        one_bit("R11 new keystream");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule